// File: doc/BRIEF.md
# Periodic Conversion Trigger Generator

This block paces an external sampler. It issues a strobe one system clock wide at a fixed rate, and each strobe starts one conversion. Software supplies the wanted spacing between samples in nanoseconds and pulses a load strobe. The block turns the request into a whole number of 250 ns ticks. It applies a lower floor and an upper cap, then counts that many ticks between strobes. The 250 ns tick comes from a prescaler on the 48 MHz system clock.

A request of zero does not make a period at all. In that case the block raises a continuous-mode flag, which tells the sampler to convert back to back, and the period counter stays idle. A separate monitor setting ignores the requested interval. It uses a 1 µs tick (one clock-MHz count of the prescaler) and a fixed 20 µs period.

Every load clears the prescaler and the period counter. The new settings therefore start from a clean period, and no strobe comes from a mix of old and new values. Dropping the enable also clears both counters. After reset, before any load, the block runs at the floor interval.

Top module: `sample_trig_gen`

## Requirements
- R1: After reset, `trig_o` and `cont_o` are both low.
- R2: A load with `cfg_monitor` low and `cfg_interval_ns` equal to 0 selects continuous mode. While enabled, `cont_o` is high from the second clock edge after the load cycle, and `trig_o` never pulses.
- R3: A load with a request above 1500 ns sets the period to floor(request/250) ticks of 12 clocks each. A request of 1999 ns therefore gives 7 ticks (84 clocks).
- R4: A nonzero request of 1500 ns or less gives a period of 6 ticks (72 clocks).
- R5: The tick count is capped at the MAX_TICKS parameter, which defaults to 65535.
- R6: Each strobe is high for exactly one clock. The first strobe after the enable goes high comes after one full period: it is high in the cycle that follows the Nth enabled clock edge, where N is the period length in clocks.
- R7: A load with `cfg_monitor` high gives a period of 20 ticks of 48 clocks (960 clocks), whatever the value of `cfg_interval_ns`.
- R8: A load applied in the middle of a period halts the generator. No strobe appears in the cycle after the load, and the next strobe comes one full new period after the load is released.
- R9: While `cfg_enable` is low, both outputs are low from the next cycle onward. Enabling again restarts the current configuration from the beginning of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 48 MHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_interval_ns | input | 32 | Requested sample spacing in ns; 0 selects continuous mode |
| cfg_monitor | input | 1 | Selects the fixed monitor timing on load |
| cfg_load | input | 1 | Single-cycle strobe that captures the configuration |
| cfg_enable | input | 1 | Runs the generator while high |
| trig_o | output | 1 | One-clock conversion start strobe |
| cont_o | output | 1 | High while continuous conversion is selected and enabled |

## Verification
The bench loads a range of requests, and each one targets a different branch of the conversion:
- 2000 ns is a plain multiple of the tick.
- 1999 ns can only give 84 clocks if the division truncates.
- 1500 ns and 1 ns sit on or below the floor.
- A very large request shows the cap.
- Zero shows continuous mode.

The monitor setting is loaded with a nonzero interval, so a result of 960 clocks proves that the request was ignored. A reload in the middle of a period and a drop of the enable followed by re-enable both check that the first strobe comes one full period after the restart and not at the old phase.

// File: rtl/stg_pkg.sv
package stg_pkg;
  typedef enum logic [1:0] {
    MODE_CONT = 2'd0,
    MODE_INTV = 2'd1,
    MODE_MON  = 2'd2
  } trig_mode_e;
endpackage

// File: rtl/stg_tick_calc.sv
// Converts a nanosecond request into a tick count with floor and cap.
module stg_tick_calc #(
  parameter int REQ_W     = 32,
  parameter int CNT_W     = 16,
  parameter int TICK_NS   = 250,
  parameter int MIN_NS    = 1500,
  parameter int MIN_TICKS = 6,
  parameter int MAX_TICKS = 65535
) (
  input  logic [REQ_W-1:0] req_ns,
  output logic [CNT_W-1:0] ticks
);
  logic [REQ_W-1:0] quot;

  always_comb begin
    quot = req_ns / REQ_W'(TICK_NS);
    if (req_ns <= REQ_W'(MIN_NS))
      ticks = CNT_W'(MIN_TICKS);
    else if (quot > REQ_W'(MAX_TICKS))
      ticks = CNT_W'(MAX_TICKS);
    else
      ticks = quot[CNT_W-1:0];
  end
endmodule

// File: rtl/stg_prescaler.sv
// Divides the system clock into ticks; last is the terminal count.
module stg_prescaler #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] last,
  output logic         tick
);
  logic [W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (run)
      cnt_d = tick ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/stg_period_ctr.sv
// Counts ticks; wrap marks the boundary between periods.
module stg_period_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] last,
  output logic         wrap
);
  logic [W-1:0] cnt_q, cnt_d;

  assign wrap = tick && (cnt_q == last);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (tick)
      cnt_d = wrap ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sample_trig_gen.sv
module sample_trig_gen #(
  parameter int CLK_MHZ   = 48,
  parameter int TICK_NS   = 250,
  parameter int MIN_NS    = 1500,
  parameter int MIN_TICKS = 6,
  parameter int MAX_TICKS = 65535,
  parameter int MON_TICKS = 20,
  parameter int REQ_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REQ_W-1:0] cfg_interval_ns,
  input  logic             cfg_monitor,
  input  logic             cfg_load,
  input  logic             cfg_enable,
  output logic             trig_o,
  output logic             cont_o
);
  import stg_pkg::*;

  localparam int PSC_INTV = CLK_MHZ * TICK_NS / 1000;
  localparam int PSC_MON  = CLK_MHZ;
  localparam int PSC_MAX  = (PSC_INTV > PSC_MON) ? PSC_INTV : PSC_MON;
  localparam int PSC_W    = (PSC_MAX > 2) ? $clog2(PSC_MAX) : 1;
  localparam int CNT_MAX  = (MAX_TICKS > MON_TICKS) ? MAX_TICKS : MON_TICKS;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // configuration capture
  logic [CNT_W-1:0] ticks_w;
  trig_mode_e       mode_q, mode_d;
  logic [CNT_W-1:0] per_last_q, per_last_d;
  logic [PSC_W-1:0] psc_last_q, psc_last_d;

  stg_tick_calc #(
    .REQ_W(REQ_W), .CNT_W(CNT_W), .TICK_NS(TICK_NS),
    .MIN_NS(MIN_NS), .MIN_TICKS(MIN_TICKS), .MAX_TICKS(MAX_TICKS)
  ) u_calc (
    .req_ns(cfg_interval_ns),
    .ticks (ticks_w)
  );

  always_comb begin
    mode_d     = mode_q;
    per_last_d = per_last_q;
    psc_last_d = psc_last_q;
    if (cfg_load) begin
      if (cfg_monitor) begin
        mode_d     = MODE_MON;
        per_last_d = CNT_W'(MON_TICKS - 1);
        psc_last_d = PSC_W'(PSC_MON - 1);
      end else begin
        mode_d     = (cfg_interval_ns == '0) ? MODE_CONT : MODE_INTV;
        per_last_d = ticks_w - CNT_W'(1);
        psc_last_d = PSC_W'(PSC_INTV - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mode_q     <= MODE_INTV;
      per_last_q <= CNT_W'(MIN_TICKS - 1);
      psc_last_q <= PSC_W'(PSC_INTV - 1);
    end else begin
      mode_q     <= mode_d;
      per_last_q <= per_last_d;
      psc_last_q <= psc_last_d;
    end
  end

  // counting chain
  logic clr, run, tick, wrap;

  assign clr = cfg_load || !cfg_enable;
  assign run = cfg_enable && !cfg_load && (mode_q != MODE_CONT);

  stg_prescaler #(.W(PSC_W)) u_psc (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr  (clr),
    .run  (run),
    .last (psc_last_q),
    .tick (tick)
  );

  stg_period_ctr #(.W(CNT_W)) u_per (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr  (clr),
    .tick (tick),
    .last (per_last_q),
    .wrap (wrap)
  );

  // output registers
  logic trig_q, trig_d, cont_q, cont_d;

  always_comb begin
    trig_d = wrap;
    cont_d = cfg_enable && !cfg_load && (mode_q == MODE_CONT);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      trig_q <= 1'b0;
      cont_q <= 1'b0;
    end else begin
      trig_q <= trig_d;
      cont_q <= cont_d;
    end
  end

  assign trig_o = trig_q;
  assign cont_o = cont_q;
endmodule

// File: rtl/stg_checker.sv
module stg_checker #(
  parameter int REQ_W     = 32,
  parameter int CNT_W     = 16,
  parameter int MIN_NS    = 1500,
  parameter int MIN_TICKS = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REQ_W-1:0] cfg_interval_ns,
  input logic             cfg_load,
  input logic             cfg_enable,
  input logic             trig_o,
  input logic             cont_o,
  input logic [CNT_W-1:0] calc_ticks
);
  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o); // R6
  AST_CONT_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    cont_o |-> !trig_o); // R2
  AST_LOAD_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (!trig_o && !cont_o)); // R8
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!trig_o && !cont_o)); // R9
  AST_TICK_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_interval_ns <= REQ_W'(MIN_NS)) |-> (calc_ticks == CNT_W'(MIN_TICKS))); // R4
endmodule

bind sample_trig_gen stg_checker #(
  .REQ_W(REQ_W), .CNT_W(CNT_W), .MIN_NS(MIN_NS), .MIN_TICKS(MIN_TICKS)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_interval_ns(cfg_interval_ns),
  .cfg_load       (cfg_load),
  .cfg_enable     (cfg_enable),
  .trig_o         (trig_o),
  .cont_o         (cont_o),
  .calc_ticks     (ticks_w)
);

// File: tb/sample_trig_gen_test.sv
module sample_trig_gen_test;
  localparam int MAX_T = 100;   // small cap keeps saturation runs short
  localparam int PSC   = 12;
  localparam int MON_N = 20 * 48;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_interval_ns;
  logic        cfg_monitor, cfg_load, cfg_enable;
  logic        trig_o, cont_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  sample_trig_gen #(.MAX_TICKS(MAX_T)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_interval_ns(cfg_interval_ns),
    .cfg_monitor(cfg_monitor), .cfg_load(cfg_load), .cfg_enable(cfg_enable),
    .trig_o(trig_o), .cont_o(cont_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every strobe must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && trig_o) begin
      if (exp_q.size() == 0)
        check(1'b0, "R6 unexpected strobe at cycle", cyc, -1);
      else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cyc == e, t, cyc, e);
      end
    end
  end

  function automatic int period_of(int ns, bit mon);
    int t;
    if (mon) return MON_N;
    if (ns <= 1500) t = 6;
    else t = ns / 250;
    if (t > MAX_T) t = MAX_T;
    return t * PSC;
  endfunction

  task automatic push_pulses(int start, int n, int cnt, string req);
    for (int k = 1; k <= cnt; k++) begin
      exp_q.push_back(start + k * n);
      tag_q.push_back(req);
    end
  endtask

  task automatic drain(string req);
    while (exp_q.size() != 0) begin
      int e;
      e = exp_q.pop_front();
      void'(tag_q.pop_front());
      check(1'b0, {req, " missing strobe"}, -1, e);
    end
  endtask

  task automatic run_case(int ns, bit mon, int cnt, string req, bit hold_en);
    int n, c;
    n = period_of(ns, mon);
    @(negedge clk);
    cfg_interval_ns = ns;
    cfg_monitor = mon;
    cfg_load = 1'b1;
    if (!hold_en) cfg_enable = 1'b0;
    @(negedge clk);
    cfg_load = 1'b0;
    cfg_enable = 1'b1;
    c = cyc;
    push_pulses(c, n, cnt, req);
    repeat (n * cnt + n / 2) @(negedge clk);
    drain(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c, n;
    rst_n = 1'b0;
    cfg_interval_ns = 0;
    cfg_monitor = 1'b0;
    cfg_load = 1'b0;
    cfg_enable = 1'b0;
    repeat (3) @(negedge clk);
    check(trig_o == 1'b0 && cont_o == 1'b0, "R1 reset outputs", {trig_o, cont_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(trig_o == 1'b0 && cont_o == 1'b0, "R1 after release", {trig_o, cont_o}, 0);

    run_case(2000, 0, 3, "R3 2000ns", 0);
    run_case(1999, 0, 2, "R3 truncation 1999ns", 0);
    run_case(1500, 0, 2, "R4 1500ns floor", 0);
    run_case(1, 0, 1, "R4 1ns floor", 0);
    run_case(100000, 0, 2, "R5 cap", 0);
    run_case(4000, 1, 2, "R7 monitor", 0);

    // R8: reload mid-period with enable kept high
    run_case(2000, 0, 1, "R3 before reload", 0);
    run_case(3000, 0, 2, "R8 reload", 1);

    // R9: disable mid-period, then resume from a fresh period
    n = period_of(3000, 0);
    repeat (n / 3) @(negedge clk);
    cfg_enable = 1'b0;
    repeat (n * 2) @(negedge clk);
    check(trig_o == 1'b0 && cont_o == 1'b0, "R9 disabled outputs", {trig_o, cont_o}, 0);
    cfg_enable = 1'b1;
    c = cyc;
    push_pulses(c, n, 2, "R9 resume");
    repeat (n * 2 + n / 2) @(negedge clk);
    drain("R9 resume");

    // R2: continuous mode
    @(negedge clk);
    cfg_interval_ns = 0;
    cfg_monitor = 1'b0;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    cfg_enable = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      check(cont_o == 1'b1, "R2 continuous flag", cont_o, 1);
      @(negedge clk);
    end
    cfg_enable = 1'b0;
    @(negedge clk);
    check(cont_o == 1'b0, "R9 continuous flag cleared", cont_o, 0);
    repeat (10) @(negedge clk);
    drain("R2 no strobe");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule